// File: doc/BRIEF.md
# LFSR Sequence Period Meter

This block measures how many steps a Fibonacci-style linear feedback shift register takes before it comes back to its starting state. The width, the tap set and the seed are chosen at runtime. A single-cycle start pulse loads them. The unit then advances its own model of the register by one step per clock. It stops when the newly produced state equals the starting state and reports the step count.

Every state the model visits is shown on a strobed output, so a testbench or monitor can log the whole sequence in order. Some tap sets are not invertible and can carry a seed into a cycle that never returns to it. For these the unit gives up after 2^N steps and raises a timeout flag.

Top module: `lfsr_period_meter`

## Requirements
- R1: The active width N comes from `width_i` (values above 32 act as 32). Seed bits at or above position N are ignored, and every state shown on `step_state_o` has all bits at or above N cleared.
- R2: Bit k-1 of `taps_i` selects stage k as a feedback tap. Tap bits at or above position N have no effect on the sequence or on the period.
- R3: Each step, the new state is the old state shifted left by one, truncated to N bits, with bit 0 set to the XOR of the old state bits selected by the taps.
- R4: When the new state equals the masked seed, the unit does three things on that same clock edge: it raises `done_o`, drops `busy_o`, and loads `period_o` with the number of steps taken, counting the final one.
- R5: A seed that masks to zero finishes after one step with `period_o` = 1.
- R6: If 2^N steps pass without the seed recurring, the unit raises `done_o` and `timeout_o` together, drops `busy_o`, and reports `period_o` = 2^N. On a normal finish `timeout_o` stays 0.
- R7: A start accepted while idle raises `busy_o` on the next edge and clears `done_o` and `timeout_o`. `start_i` is ignored while `busy_o` is high. `done_o` and `period_o` hold their values until the next accepted start.
- R8: `step_valid_o` is high for exactly one cycle per step, including the final matching step, with `step_state_o` carrying the new state. It is low whenever no step was taken on the previous edge.
- R9: After reset, `busy_o`, `done_o`, `timeout_o` and `step_valid_o` are 0 and `period_o` is 0.
- R10: Widths up to 32 are supported, and the step count is 33 bits wide so that 2^32 can be represented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| width_i | input | 6 | Number of active stages N |
| taps_i | input | 32 | Tap mask, bit k-1 selects stage k |
| seed_i | input | 32 | Starting state |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | Measurement finished, held until next start |
| timeout_o | output | 1 | Seed not revisited within 2^N steps |
| period_o | output | 33 | Number of steps taken |
| step_valid_o | output | 1 | One pulse per step |
| step_state_o | output | 32 | State produced by the step |

## Verification
A wrong feedback bit or a bad mask corrupts the state register, and that state appears on `step_state_o` at the very next edge. Comparing every strobed state against an independent model therefore catches the fault within one cycle of its cause, long before the period count is wrong. A miscounting step counter shows up only at the finish, as a wrong `period_o` or as a spurious or missing timeout. The cases chosen are a full-length 16-bit run, the 32-bit rotation, a zero seed and a non-returning seed, so that such a counter error reaches the ports.

// File: rtl/lfsr_pm_pkg.sv
// Shared definitions for the LFSR period meter.
// Assumes: MAX_W no larger than 32 for the default build.
package lfsr_pm_pkg;
    typedef enum logic {
        PM_IDLE = 1'b0,
        PM_RUN  = 1'b1
    } pm_fsm_e;
endpackage

// File: rtl/lfsr_pm_mask.sv
// Width-to-mask decoder: sets the low WIDTH bits of the mask.
// Assumes: widths above MAX_W saturate to all ones; width 0 gives an empty mask.
module lfsr_pm_mask #(
    parameter int MAX_W = 32,
    parameter int WW    = $clog2(MAX_W + 1)
) (
    input  logic [WW-1:0]    width_i,
    output logic [MAX_W-1:0] mask_o
);
    // One comparator per bit position.
    for (genvar i = 0; i < MAX_W; i++) begin : g_bit
        assign mask_o[i] = (width_i > WW'(i));
    end
endmodule

// File: rtl/lfsr_pm_step.sv
// Single Fibonacci step: shift left, truncate, insert tap parity at bit 0.
// Assumes: taps_i and state_i are already restricted to the active width.
module lfsr_pm_step #(
    parameter int MAX_W = 32
) (
    input  logic [MAX_W-1:0] state_i,
    input  logic [MAX_W-1:0] taps_i,
    input  logic [MAX_W-1:0] mask_i,
    output logic [MAX_W-1:0] next_o
);
    logic fb;

    // Feedback parity over the tapped stages, then shift.
    always_comb begin
        fb     = ^(state_i & taps_i);
        next_o = ({state_i[MAX_W-2:0], 1'b0} & mask_i) | {{(MAX_W-1){1'b0}}, fb};
    end
endmodule

// File: rtl/lfsr_pm_counter.sv
// Saturating step counter with synchronous clear.
// Assumes: clr_i has priority over inc_i.
module lfsr_pm_counter #(
    parameter int CW = 33
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cnt_next_o
);
    logic [CW-1:0] cnt_q;

    // Next value stops at all ones.
    always_comb cnt_next_o = (cnt_q == {CW{1'b1}}) ? cnt_q : cnt_q + CW'(1);

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (inc_i) cnt_q <= cnt_next_o;
    end

    assign cnt_o = cnt_q;

    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i) |=> (cnt_q != '0));
endmodule

// File: rtl/lfsr_period_meter.sv
// LFSR period meter: runs a Fibonacci LFSR model from a seed until the seed
// recurs or 2^N steps pass, reporting the step count.
// Assumes: inputs are sampled only on an accepted start; one step per clock.
module lfsr_period_meter #(
    parameter int MAX_W = 32,
    parameter int WW    = $clog2(MAX_W + 1),
    parameter int CW    = MAX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WW-1:0]    width_i,
    input  logic [MAX_W-1:0] taps_i,
    input  logic [MAX_W-1:0] seed_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             timeout_o,
    output logic [CW-1:0]    period_o,
    output logic             step_valid_o,
    output logic [MAX_W-1:0] step_state_o
);
    import lfsr_pm_pkg::*;

    pm_fsm_e          fsm_q;
    logic [MAX_W-1:0] mask_w, mask_q, taps_q, seed_q, state_q, next_w;
    logic [CW-1:0]    cnt_w, cnt_next_w, limit_w, period_q;
    logic             done_q, tmo_q, vld_q, accept_w, run_w;
    logic [MAX_W-1:0] out_q;

    lfsr_pm_mask #(.MAX_W(MAX_W), .WW(WW)) u_mask (
        .width_i (width_i),
        .mask_o  (mask_w)
    );

    lfsr_pm_step #(.MAX_W(MAX_W)) u_step (
        .state_i (state_q),
        .taps_i  (taps_q),
        .mask_i  (mask_q),
        .next_o  (next_w)
    );

    lfsr_pm_counter #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (accept_w),
        .inc_i      (run_w),
        .cnt_o      (cnt_w),
        .cnt_next_o (cnt_next_w)
    );

    // Start is taken only while idle; the counter advances on every run cycle.
    always_comb begin
        accept_w = start_i && (fsm_q == PM_IDLE);
        run_w    = (fsm_q == PM_RUN);
        limit_w  = {1'b0, mask_q} + CW'(1);
    end

    // Control, state and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q    <= PM_IDLE;
            mask_q   <= '0;
            taps_q   <= '0;
            seed_q   <= '0;
            state_q  <= '0;
            done_q   <= 1'b0;
            tmo_q    <= 1'b0;
            period_q <= '0;
            vld_q    <= 1'b0;
            out_q    <= '0;
        end else begin
            vld_q <= 1'b0;
            if (accept_w) begin
                mask_q   <= mask_w;
                taps_q   <= taps_i & mask_w;
                seed_q   <= seed_i & mask_w;
                state_q  <= seed_i & mask_w;
                done_q   <= 1'b0;
                tmo_q    <= 1'b0;
                period_q <= '0;
                fsm_q    <= PM_RUN;
            end else if (run_w) begin
                vld_q   <= 1'b1;
                out_q   <= next_w;
                state_q <= next_w;
                if (next_w == seed_q) begin
                    done_q   <= 1'b1;
                    period_q <= cnt_next_w;
                    fsm_q    <= PM_IDLE;
                end else if (cnt_next_w == limit_w) begin
                    done_q   <= 1'b1;
                    tmo_q    <= 1'b1;
                    period_q <= cnt_next_w;
                    fsm_q    <= PM_IDLE;
                end
            end
        end
    end

    assign busy_o       = (fsm_q == PM_RUN);
    assign done_o       = done_q;
    assign timeout_o    = tmo_q;
    assign period_o     = period_q;
    assign step_valid_o = vld_q;
    assign step_state_o = out_q;

    // Strobed states never carry bits above the active width.
    assert_state_in_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid_o |-> ((step_state_o & ~mask_q) == '0));
    // A finish always leaves the running state.
    assert_done_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> !busy_o);
    // A finish without timeout means the strobed state is the seed.
    assert_match_on_finish_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_o) && !timeout_o) |-> (step_state_o == seed_q));
    // Timeout only together with done.
    assert_timeout_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> done_o);
    // Start while running leaves the captured seed untouched.
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(seed_q));
    // Done and period hold until the next start.
    assert_done_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(period_o)));
    // A strobe only follows a running cycle.
    assert_valid_after_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid_o |-> $past(busy_o));
endmodule

// File: tb/lfsr_period_meter_tb.sv
module lfsr_period_meter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  width_i = '0;
    logic [31:0] taps_i = '0;
    logic [31:0] seed_i = '0;
    logic        busy_o, done_o, timeout_o, step_valid_o;
    logic [32:0] period_o;
    logic [31:0] step_state_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    lfsr_period_meter u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .width_i(width_i),
        .taps_i(taps_i), .seed_i(seed_i), .busy_o(busy_o), .done_o(done_o),
        .timeout_o(timeout_o), .period_o(period_o),
        .step_valid_o(step_valid_o), .step_state_o(step_state_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic longint wmask(input int w);
        return (w >= 32) ? 64'hFFFF_FFFF : ((64'd1 << w) - 1);
    endfunction

    // Runs one measurement against a behavioural model; returns steps taken.
    task automatic run(input int w, input longint taps, input longint seed,
                       input int poke_at, output longint steps, output bit tmo);
        longint m, s, s0, lim, nx;
        longint n;
        bit fin;
        m = wmask(w);
        s = seed & m; s0 = s; lim = longint'(m) + 1; n = 0; fin = 0;
        @(negedge clk);
        width_i = 6'(w); taps_i = 32'(taps); seed_i = 32'(seed); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R7 busy after start", longint'(busy_o), 1);
        chk(done_o == 1'b0 && timeout_o == 1'b0, "R7 done cleared", longint'(done_o), 0);
        chk(step_valid_o == 1'b0, "R8 no strobe on load", longint'(step_valid_o), 0);
        while (!fin) begin
            nx = ((s << 1) & m) | longint'(^(s & taps & m));
            n++;
            if (n == poke_at) begin
                start_i = 1'b1; seed_i = ~seed_i; width_i = 6'd3; taps_i = '1;
            end
            @(negedge clk);
            start_i = 1'b0;
            chk(step_valid_o == 1'b1, "R8 strobe per step", longint'(step_valid_o), 1);
            chk(step_state_o == 32'(nx), "R3 next state", longint'(step_state_o), nx);
            chk((step_state_o & ~32'(m)) == '0, "R1 state masked", longint'(step_state_o), nx);
            s = nx;
            if (s == s0 || n == lim) begin
                fin = 1;
                chk(done_o == 1'b1, "R4 done on finish", longint'(done_o), 1);
                chk(busy_o == 1'b0, "R4 busy dropped", longint'(busy_o), 0);
                chk(period_o == 33'(n), "R4 period count", longint'(period_o), n);
                chk(timeout_o == (s != s0), "R6 timeout flag", longint'(timeout_o), longint'(s != s0));
            end else begin
                chk(done_o == 1'b0 && busy_o == 1'b1, "R7 running", longint'(done_o), 0);
            end
        end
        repeat (2) begin
            @(negedge clk);
            chk(step_valid_o == 1'b0, "R8 no strobe after finish", longint'(step_valid_o), 0);
            chk(done_o == 1'b1, "R7 done held", longint'(done_o), 1);
            chk(period_o == 33'(n), "R7 period held", longint'(period_o), n);
        end
        steps = n; tmo = (s != s0);
    endtask

    initial begin
        longint p;
        bit t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && !timeout_o && !step_valid_o, "R9 reset outputs",
            {busy_o, done_o, timeout_o, step_valid_o}, 0);
        chk(period_o == '0, "R9 reset period", longint'(period_o), 0);

        run(4, 64'hC, 64'h1, 0, p, t);
        chk(p == 15, "R3 4-bit maximal period", p, 15);
        run(4, 64'hFFF0_000C, 64'hFFF1, 5, p, t);
        chk(p == 15 && !t, "R2 taps above width ignored", p, 15);
        run(8, 64'h8E, 64'h5A, 0, p, t);
        run(8, 64'h0, 64'h300, 0, p, t);
        chk(p == 1, "R5 zero seed after masking", p, 1);
        run(4, 64'h1, 64'h2, 0, p, t);
        chk(p == 16 && t, "R6 timeout at 2^N", p, 16);
        run(32, 64'h8000_0000, 64'h1, 7, p, t);
        chk(p == 32, "R10 32-bit rotation", p, 32);
        run(32, 64'h0, 64'h0, 0, p, t);
        chk(p == 1, "R5 zero seed width 32", p, 1);
        run(12, 64'hE08, 64'h123, 100, p, t);
        run(16, 64'hD008, 64'hACE1, 0, p, t);
        chk(p == 65535 && !t, "R10 16-bit full period", p, 65535);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule